// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block lets a driver queue several frames for transmission with a single command. The frames and a circular table of 8-byte descriptors sit in a byte-wide buffer memory. After a `go` pulse the engine starts at its table pointer and reads each entry's ownership byte. For an entry marked for sending it fetches the frame's start address, byte count and configuration byte, hands the entry back by clearing the ownership byte, and starts the frame transmitter. When the transmitter reports completion, the engine writes the transmit status and collision count back into the entry, advances the pointer and moves to the next entry.

The chain ends on the first entry that is not marked for sending, on a transmit abort, or at the first entry boundary after a stop request. Each time a chain ends the engine raises a one-cycle interrupt. The table pointer always names the first entry that has not been processed, so a later `go` resumes the chain there without losing a frame. The ring is given as a begin page and an end page. The end page lies outside the ring, and the pointer wraps from the end page back to the begin page.

Descriptor layout, as byte offsets within an entry:
- 0: ownership/status.
- 1: collision count.
- 2 and 3: start address, high byte first.
- 4 and 5: byte count, high byte first.
- 6: configuration.
- 7: unused.

Top module: `txring_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `irq`, `tx_start` and `mem_req` are 0 and `tab_ptr` equals `cfg_ptr_init`.
- R2: A chain begins by reading byte 0 of the entry at `tab_ptr`. If that byte is 8'hFF, `tx_start` pulses for one cycle with these values: `tx_addr` = {byte2,byte3}, `tx_len` = {byte4,byte5}, `tx_cfg` = byte6.
- R3: For an entry that is sent, byte 0 is written to 8'h00 after bytes 2 to 6 have been read and before `tx_start` pulses.
- R4: If byte 0 is not 8'hFF, no frame is started, the entry stays unchanged, `tab_ptr` does not move and the chain ends.
- R5: On `tx_done` the engine writes `tx_status` to byte 0 and `tx_coll` to byte 1. It then advances `tab_ptr` by 8 and processes the next entry.
- R6: When `tab_ptr`+8 has an upper byte equal to `cfg_ring_end`, the pointer becomes {`cfg_ring_begin`, 8'h00}.
- R7: If `tx_abort` is high with `tx_done`, the result is written back and the pointer advances, but no further entry is read and the chain ends.
- R8: A `stop` pulse while busy lets the current frame complete. No further entry is read after it, and `tab_ptr` names the next entry, whose byte 0 is left untouched.
- R9: `go` has no effect while `busy` is high.
- R10: A memory access completes only in a cycle with `mem_req` and `mem_ready` both high. While it waits, address, direction and write data hold steady. `mem_req` is never high while the engine is idle.
- R11: `irq` is high for exactly one cycle each time a chain ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the table pointer |
| cfg_ring_begin | input | 8 | Upper address byte of the first ring location |
| cfg_ring_end | input | 8 | Upper address byte of the first location past the ring |
| cfg_ptr_init | input | 16 | Table pointer value loaded at reset |
| go | input | 1 | Start processing the chain (ignored while busy) |
| stop | input | 1 | Finish the current frame, then halt at the next entry |
| busy | output | 1 | Chain is being processed |
| tab_ptr | output | 16 | Address of the current or first unprocessed entry |
| irq | output | 1 | One-cycle transmit-complete pulse at chain end |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid when `mem_ready` is high |
| mem_ready | input | 1 | Memory completes the access this cycle |
| tx_start | output | 1 | One-cycle pulse starting a frame |
| tx_addr | output | 16 | Frame start address |
| tx_len | output | 16 | Frame byte count |
| tx_cfg | output | 8 | Frame configuration byte |
| tx_done | input | 1 | Frame finished (one cycle) |
| tx_status | input | 8 | Transmit status of the finished frame |
| tx_coll | input | 8 | Collision count of the finished frame |
| tx_abort | input | 1 | Frame aborted after too many collisions |

## Verification
The first chain starts two entries before the ring end, so three marked frames cross the wrap and then stop at a cleared entry. This separates correct wrapping and correct halting from an off-by-one in either. Later runs try an abort on a frame whose successor is marked, a stop issued during a frame whose successor is marked, and a `go` on an entry that is not marked. Each run distinguishes "chain ends here" from "one entry too many or too few". Memory readiness follows a pseudo-random pattern throughout, so every descriptor byte is fetched under stalls, and a spurious `go` during a busy chain shows whether the engine restarts.

// File: rtl/txring_pkg.sv
package txring_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int PAGE_W = 8;
    localparam int OFS_W  = 3;                 // 8-byte entries
    localparam int ENTRY_BYTES = 1 << OFS_W;

    localparam logic [DATA_W-1:0] OWN_SEND  = 8'hFF;
    localparam logic [DATA_W-1:0] OWN_CLEAR = 8'h00;

    localparam logic [OFS_W-1:0] OFS_STAT = 3'd0;
    localparam logic [OFS_W-1:0] OFS_COLL = 3'd1;
    localparam logic [OFS_W-1:0] OFS_AHI  = 3'd2;
    localparam logic [OFS_W-1:0] OFS_ALO  = 3'd3;
    localparam logic [OFS_W-1:0] OFS_LHI  = 3'd4;
    localparam logic [OFS_W-1:0] OFS_LLO  = 3'd5;
    localparam logic [OFS_W-1:0] OFS_CFG  = 3'd6;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_OWN,
        ST_RD_BODY,
        ST_WR_OWN,
        ST_TX_GO,
        ST_TX_WAIT,
        ST_WR_STAT,
        ST_WR_COLL,
        ST_END
    } ring_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] len;
        logic [DATA_W-1:0] cfg;
    } frame_desc_t;

    typedef struct packed {
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] coll;
        logic              abort;
    } tx_result_t;

    function automatic logic [ADDR_W-1:0] ring_next(
        input logic [ADDR_W-1:0] cur,
        input logic [PAGE_W-1:0] pg_begin,
        input logic [PAGE_W-1:0] pg_end
    );
        logic [ADDR_W-1:0] nxt;
        nxt = cur + ADDR_W'(ENTRY_BYTES);
        if (nxt[ADDR_W-1 -: PAGE_W] == pg_end)
            nxt = {pg_begin, {(ADDR_W-PAGE_W){1'b0}}};
        return nxt;
    endfunction

endpackage

// File: rtl/txring_ptr.sv
module txring_ptr
    import txring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] init_ptr,
    input  logic [PAGE_W-1:0] pg_begin,
    input  logic [PAGE_W-1:0] pg_end,
    input  logic              advance,
    output logic [ADDR_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr <= init_ptr;
        else if (advance)
            ptr <= ring_next(ptr, pg_begin, pg_end);
    end
endmodule

// File: rtl/txring_desc.sv
module txring_desc
    import txring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] byte_in,
    output frame_desc_t       desc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            desc <= '0;
        end else if (cap) begin
            case (ofs)
                OFS_AHI: desc.start[ADDR_W-1 -: DATA_W] <= byte_in;
                OFS_ALO: desc.start[DATA_W-1:0]         <= byte_in;
                OFS_LHI: desc.len[ADDR_W-1 -: DATA_W]   <= byte_in;
                OFS_LLO: desc.len[DATA_W-1:0]           <= byte_in;
                OFS_CFG: desc.cfg                       <= byte_in;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/txring_engine.sv
module txring_engine
    import txring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PAGE_W-1:0] cfg_ring_begin,
    input  logic [PAGE_W-1:0] cfg_ring_end,
    input  logic [ADDR_W-1:0] cfg_ptr_init,
    input  logic              go,
    input  logic              stop,
    output logic              busy,
    output logic [ADDR_W-1:0] tab_ptr,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              tx_start,
    output logic [ADDR_W-1:0] tx_addr,
    output logic [ADDR_W-1:0] tx_len,
    output logic [DATA_W-1:0] tx_cfg,
    input  logic              tx_done,
    input  logic [DATA_W-1:0] tx_status,
    input  logic [DATA_W-1:0] tx_coll,
    input  logic              tx_abort
);
    ring_state_e state, state_nx;
    logic [OFS_W-1:0] body_ofs;
    logic [OFS_W-1:0] cur_ofs;
    tx_result_t       result;
    logic             stop_pend;
    logic             acc;
    logic             advance;
    frame_desc_t      desc;

    txring_ptr u_ptr (
        .clk      (clk),
        .rst      (rst),
        .init_ptr (cfg_ptr_init),
        .pg_begin (cfg_ring_begin),
        .pg_end   (cfg_ring_end),
        .advance  (advance),
        .ptr      (tab_ptr)
    );

    txring_desc u_desc (
        .clk     (clk),
        .rst     (rst),
        .cap     (state == ST_RD_BODY && acc),
        .ofs     (body_ofs),
        .byte_in (mem_rdata),
        .desc    (desc)
    );

    // memory port decode from the current state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = OWN_CLEAR;
        cur_ofs   = OFS_STAT;
        case (state)
            ST_RD_OWN:  mem_req = 1'b1;
            ST_RD_BODY: begin mem_req = 1'b1; cur_ofs = body_ofs; end
            ST_WR_OWN:  begin mem_req = 1'b1; mem_we = 1'b1; end
            ST_WR_STAT: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = result.stat; end
            ST_WR_COLL: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_wdata = result.coll; cur_ofs = OFS_COLL;
            end
            default: ;
        endcase
    end

    assign mem_addr = {tab_ptr[ADDR_W-1:OFS_W], cur_ofs};
    assign acc      = mem_req && mem_ready;
    assign advance  = (state == ST_WR_COLL) && acc;
    assign busy     = (state != ST_IDLE);
    assign irq      = (state == ST_END);
    assign tx_start = (state == ST_TX_GO);
    assign tx_addr  = desc.start;
    assign tx_len   = desc.len;
    assign tx_cfg   = desc.cfg;

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:    if (go) state_nx = ST_RD_OWN;
            ST_RD_OWN:  if (acc) state_nx = (mem_rdata == OWN_SEND) ? ST_RD_BODY : ST_END;
            ST_RD_BODY: if (acc && body_ofs == OFS_CFG) state_nx = ST_WR_OWN;
            ST_WR_OWN:  if (acc) state_nx = ST_TX_GO;
            ST_TX_GO:   state_nx = ST_TX_WAIT;
            ST_TX_WAIT: if (tx_done) state_nx = ST_WR_STAT;
            ST_WR_STAT: if (acc) state_nx = ST_WR_COLL;
            ST_WR_COLL: if (acc) state_nx = (result.abort || stop_pend) ? ST_END : ST_RD_OWN;
            ST_END:     state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            body_ofs  <= OFS_AHI;
            result    <= '0;
            stop_pend <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_RD_OWN)
                body_ofs <= OFS_AHI;
            else if (state == ST_RD_BODY && acc)
                body_ofs <= body_ofs + 1'b1;
            if (state == ST_TX_WAIT && tx_done)
                result <= '{stat: tx_status, coll: tx_coll, abort: tx_abort};
            if (state == ST_IDLE)
                stop_pend <= 1'b0;
            else if (stop)
                stop_pend <= 1'b1;
        end
    end
endmodule

// File: rtl/txring_engine_chk.sv
module txring_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        irq,
    input logic        tx_start,
    input logic        mem_req,
    input logic        mem_ready,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic [7:0]  mem_wdata,
    input logic [15:0] tab_ptr,
    input logic [7:0]  cfg_ring_begin
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R10
    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy); // R10
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R11
    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start); // R2
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> busy); // R2
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (tab_ptr != $past(tab_ptr)) |->
        (tab_ptr == $past(tab_ptr) + 16'd8 || tab_ptr == {cfg_ring_begin, 8'h00})); // R6
endmodule

bind txring_engine txring_engine_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .busy           (busy),
    .irq            (irq),
    .tx_start       (tx_start),
    .mem_req        (mem_req),
    .mem_ready      (mem_ready),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .tab_ptr        (tab_ptr),
    .cfg_ring_begin (cfg_ring_begin)
);

// File: tb/txring_engine_tb.sv
`timescale 1ns/1ps
module txring_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_ring_begin = 8'h02;
    logic [7:0]  cfg_ring_end   = 8'h04;
    logic [15:0] cfg_ptr_init   = 16'h03F0;
    logic        go = 1'b0, stop = 1'b0;
    logic        busy, irq, mem_req, mem_we, mem_ready, tx_start;
    logic [15:0] tab_ptr, mem_addr, tx_addr, tx_len;
    logic [7:0]  mem_wdata, mem_rdata, tx_cfg;
    logic        tx_done = 1'b0, tx_abort = 1'b0;
    logic [7:0]  tx_status = 8'h00, tx_coll = 8'h00;

    always #10 clk = ~clk;

    txring_engine u_dut (
        .clk(clk), .rst(rst), .cfg_ring_begin(cfg_ring_begin), .cfg_ring_end(cfg_ring_end),
        .cfg_ptr_init(cfg_ptr_init), .go(go), .stop(stop), .busy(busy), .tab_ptr(tab_ptr),
        .irq(irq), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .tx_start(tx_start), .tx_addr(tx_addr), .tx_len(tx_len), .tx_cfg(tx_cfg),
        .tx_done(tx_done), .tx_status(tx_status), .tx_coll(tx_coll), .tx_abort(tx_abort)
    );

    // behavioural buffer memory
    logic [7:0] mem [0:4095];
    assign mem_rdata = mem[mem_addr[11:0]];
    always @(posedge clk)
        if (mem_req && mem_we && mem_ready) mem[mem_addr[11:0]] <= mem_wdata;

    int checks = 0, fails = 0;
    int irq_count = 0, start_count = 0, cycles = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected frames, in chain order
    typedef struct {
        logic [15:0] a; logic [15:0] l; logic [7:0] c;
        logic [7:0] st; logic [7:0] co; bit ab;
    } frame_t;
    frame_t expq[$];

    task automatic put_entry(input logic [15:0] ea, input logic [7:0] own, input frame_t f);
        mem[ea[11:0]]         <= own;
        mem[ea[11:0] + 12'd1] <= 8'h00;
        mem[ea[11:0] + 12'd2] <= f.a[15:8];
        mem[ea[11:0] + 12'd3] <= f.a[7:0];
        mem[ea[11:0] + 12'd4] <= f.l[15:8];
        mem[ea[11:0] + 12'd5] <= f.l[7:0];
        mem[ea[11:0] + 12'd6] <= f.c;
        if (own == 8'hFF) expq.push_back(f);
    endtask

    // ready pattern, transmitter model and per-cycle monitors
    logic [15:0] lfsr = 16'hACE1;
    logic        prev_irq = 1'b0;
    int          delay = 0;
    frame_t      cur;
    always @(negedge clk) begin
        cycles++;
        lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ready = lfsr[0] | lfsr[3];
        tx_done   = 1'b0;
        if (!rst) begin
            if (irq) irq_count++;
            if (irq && prev_irq) check(0, "R11 irq wider than one cycle", 1, 0);
            if (mem_req && !busy) check(0, "R10 request while idle", 1, 0);
            if (tx_start) begin
                start_count++;
                if (expq.size() == 0) begin
                    check(0, "R2 unexpected tx_start", tx_addr, 0);
                end else begin
                    cur = expq.pop_front();
                    check(tx_addr == cur.a, "R2 tx_addr", tx_addr, cur.a);
                    check(tx_len == cur.l, "R2 tx_len", tx_len, cur.l);
                    check(tx_cfg == cur.c, "R2 tx_cfg", tx_cfg, cur.c);
                    check(mem[tab_ptr[11:0]] == 8'h00, "R3 ownership cleared before start",
                          mem[tab_ptr[11:0]], 8'h00);
                    delay = 4;
                end
            end else if (delay > 0) begin
                delay--;
                if (delay == 0) begin
                    tx_done = 1'b1; tx_status = cur.st; tx_coll = cur.co; tx_abort = cur.ab;
                end
            end
        end
        prev_irq = irq;
    end

    task automatic run_chain(input bit extra_go, input bit do_stop);
        int t0, s0;
        t0 = irq_count;
        s0 = start_count;
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
        if (extra_go) begin
            repeat (6) @(negedge clk);
            go = 1'b1;
            @(negedge clk); go = 1'b0;
        end
        if (do_stop) begin
            while (start_count == s0 && cycles < 100000) @(negedge clk);
            stop = 1'b1;
            @(negedge clk); stop = 1'b0;
        end
        while (irq_count == t0 && cycles < 100000) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        frame_t f;
        for (int i = 0; i < 4096; i++) mem[i] <= 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(tx_start == 1'b0, "R1 tx_start", tx_start, 0);
        check(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
        check(tab_ptr == 16'h03F0, "R1 tab_ptr", tab_ptr, 16'h03F0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && tab_ptr == 16'h03F0, "R1 after release", {busy, tab_ptr}, 16'h03F0);

        // chain 1: three frames across the wrap, halt at a cleared entry
        f = '{a:16'h0800, l:16'h0040, c:8'h01, st:8'h21, co:8'h00, ab:0}; put_entry(16'h03F0, 8'hFF, f);
        f = '{a:16'h0900, l:16'h05DC, c:8'h02, st:8'h23, co:8'h03, ab:0}; put_entry(16'h03F8, 8'hFF, f);
        f = '{a:16'h0A00, l:16'h0012, c:8'h04, st:8'h25, co:8'h01, ab:0}; put_entry(16'h0200, 8'hFF, f);
        f = '{a:16'h0B00, l:16'h0100, c:8'h08, st:8'h00, co:8'h00, ab:0}; put_entry(16'h0208, 8'h00, f);
        run_chain(1'b1, 1'b0);
        check(start_count == 3, "R5 frames in chain 1", start_count, 3);
        check(expq.size() == 0, "R9 no extra frames from go while busy", expq.size(), 0);
        check(mem[12'h3F0] == 8'h21 && mem[12'h3F1] == 8'h00, "R5 writeback entry 3F0",
              {mem[12'h3F0], mem[12'h3F1]}, 16'h2100);
        check(mem[12'h3F8] == 8'h23 && mem[12'h3F9] == 8'h03, "R5 writeback entry 3F8",
              {mem[12'h3F8], mem[12'h3F9]}, 16'h2303);
        check(mem[12'h200] == 8'h25 && mem[12'h201] == 8'h01, "R6 writeback after wrap",
              {mem[12'h200], mem[12'h201]}, 16'h2501);
        check(tab_ptr == 16'h0208, "R6 R4 pointer after wrap and halt", tab_ptr, 16'h0208);
        check(mem[12'h208] == 8'h00 && mem[12'h20A] == 8'h0B, "R4 halting entry unchanged",
              {mem[12'h208], mem[12'h20A]}, 16'h000B);
        check(irq_count == 1, "R11 one irq for chain 1", irq_count, 1);

        // chain 2: abort on the first frame, successor stays marked
        f = '{a:16'h0C00, l:16'h0040, c:8'h11, st:8'h8A, co:8'h0F, ab:1}; put_entry(16'h0208, 8'hFF, f);
        f = '{a:16'h0D00, l:16'h0020, c:8'h12, st:8'h31, co:8'h00, ab:0}; put_entry(16'h0210, 8'hFF, f);
        run_chain(1'b0, 1'b0);
        check(start_count == 4, "R7 only one frame on abort", start_count, 4);
        check(mem[12'h208] == 8'h8A && mem[12'h209] == 8'h0F, "R7 abort status written",
              {mem[12'h208], mem[12'h209]}, 16'h8A0F);
        check(tab_ptr == 16'h0210 && mem[12'h210] == 8'hFF, "R7 pointer and next entry",
              {tab_ptr, mem[12'h210]}, {16'h0210, 8'hFF});
        check(irq_count == 2, "R11 irq on abort", irq_count, 2);

        // chain 3: stop during the first frame
        f = '{a:16'h0E00, l:16'h0030, c:8'h13, st:8'h41, co:8'h02, ab:0}; put_entry(16'h0218, 8'hFF, f);
        run_chain(1'b0, 1'b1);
        check(start_count == 5, "R8 stop lets one frame finish", start_count, 5);
        check(mem[12'h210] == 8'h31, "R8 stopped frame written back", mem[12'h210], 8'h31);
        check(tab_ptr == 16'h0218 && mem[12'h218] == 8'hFF, "R8 pointer at first unprocessed",
              {tab_ptr, mem[12'h218]}, {16'h0218, 8'hFF});
        check(irq_count == 3, "R11 irq on stop", irq_count, 3);
        void'(expq.pop_front());

        // chain 4: go on an entry that is not marked
        mem[12'h218] <= 8'h7E;
        run_chain(1'b0, 1'b0);
        check(start_count == 5, "R4 no frame for unmarked entry", start_count, 5);
        check(tab_ptr == 16'h0218 && mem[12'h218] == 8'h7E, "R4 pointer and byte unchanged",
              {tab_ptr, mem[12'h218]}, {16'h0218, 8'h7E});
        check(irq_count == 4, "R11 irq for unmarked entry", irq_count, 4);
        check(busy == 1'b0, "R10 idle at end", busy, 0);

        if (cycles >= 100000) check(0, "watchdog expired", cycles, 100000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule